// File: doc/BRIEF.md
# Indirect Channel Configuration Port

This block is a memory-mapped slave that reaches a per-channel configuration space through a small window of direct registers. To make an access, the host writes three registers: one for the logical channel, one for the word offset inside that channel, and one for the data word when it is writing. It then writes a control word that holds an access mode and a read or write strobe. The block accepts the command and raises a busy flag. It holds that flag for a fixed number of cycles and then completes the access against an internal banked store. The result of a read is left in the data register for the host to fetch.

Each channel has a 9-bit offset space, but only the lowest part of it is backed by storage. The host polls busy, either through the status register or through the dedicated busy pin, before it issues the next step. While an access is in flight, the window is frozen, so the host cannot disturb the access.

Top module: `chan_cfg_port`

## Requirements
- R1: After reset, busy is 0. The channel, offset, data and control/status registers read 0, and every stored word is 0.
- R2: The direct registers decode as follows. Address 0x38 holds a 2-bit channel, 0x3B a 9-bit offset, and 0x3C a 16-bit data word. Each reads back what was written, with the upper bus bits at zero. Reads of any other address, apart from 0x3A, return 0.
- R3: The control/status register is at 0x3A. Bit 8 reads busy, bits [3:2] read the stored mode, and bits [1:0] always read 0. Writing 0x4 sets mode 1 and starts no access.
- R4: A write to 0x3A starts an access only when its bits [3:2] equal 1 and exactly one strobe is set. Bit 1 set starts a read (0x6) and bit 0 set starts a write (0x5).
- R5: A control write with both bit 1 and bit 0 set starts no access and leaves busy at 0. Its mode field is still stored.
- R6: A control write whose mode field is not 1 starts no access, even if a strobe is set.
- R7: Busy rises on the clock edge that accepts a command and stays at 1 for exactly 4 cycles.
- R8: While busy is 1, writes to 0x38, 0x3B, 0x3C and 0x3A are ignored. Reads of 0x3A still return the live status, with bit 8 set.
- R9: When a read access completes, the data register holds the stored word at the latched channel and offset. When a write access completes, the data register value is committed to that word.
- R10: Each channel has its own words at offsets 0 to 31. Offsets from 32 to 511 are unmapped: a read returns 0 and a write is discarded without changing any stored word.
- R11: Read data of the direct window appears on host_rdata, with host_rvalid at 1, in the cycle after host_rd is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 7 | Direct register address |
| host_wr | input | 1 | Write strobe for the direct window |
| host_wdata | input | 32 | Write data |
| host_rd | input | 1 | Read strobe for the direct window |
| host_rdata | output | 32 | Registered read data |
| host_rvalid | output | 1 | host_rdata is valid this cycle |
| busy | output | 1 | Indirect access in flight |

## Verification
The assertions assume that host_wr and host_rd are never high in the same cycle, and that both stay low while rst_n is low. They also assume that host_wdata is meaningful only when host_wr is high. The stimulus keeps to these assumptions because one task drives each bus cycle and returns the strobe to 0 before the next task starts.

Commands, and writes that must be ignored, are issued both in idle cycles and while busy is set. Writes aimed at busy windows are placed so that they land on the last busy edge. A reference array of channel words in the bench predicts every value read back through the data register.

// File: rtl/chan_cfg_port.sv
module chan_cfg_port #(
  parameter int NUM_CH    = 4,
  parameter int DATA_W    = 16,
  parameter int OFFS_W    = 9,
  parameter int MAP_DEPTH = 32,
  parameter int LATENCY   = 4,
  parameter int ADDR_W    = 7,
  parameter int BUS_W     = 32,
  parameter logic [ADDR_W-1:0] A_CHAN = 7'h38,
  parameter logic [ADDR_W-1:0] A_CSR  = 7'h3A,
  parameter logic [ADDR_W-1:0] A_OFFS = 7'h3B,
  parameter logic [ADDR_W-1:0] A_DATA = 7'h3C,
  parameter logic [1:0]        ACC_MODE = 2'd1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic [BUS_W-1:0]  host_wdata,
  input  logic              host_rd,
  output logic [BUS_W-1:0]  host_rdata,
  output logic              host_rvalid,
  output logic              busy
);

  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int MAP_W   = (MAP_DEPTH > 1) ? $clog2(MAP_DEPTH) : 1;
  localparam int IDX_W   = CH_W + MAP_W;
  localparam int ENTRIES = 1 << IDX_W;
  localparam int CNT_W   = $clog2(LATENCY + 1);

  logic [CH_W-1:0]   chan_q;
  logic [OFFS_W-1:0] offs_q;
  logic [DATA_W-1:0] data_q;
  logic [1:0]        mode_q;
  logic              busy_q;
  logic              op_rd_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] mem [ENTRIES];

  wire wr_chan = host_wr && !busy_q && host_addr == A_CHAN;
  wire wr_offs = host_wr && !busy_q && host_addr == A_OFFS;
  wire wr_data = host_wr && !busy_q && host_addr == A_DATA;
  wire wr_csr  = host_wr && !busy_q && host_addr == A_CSR;

  wire cmd_go  = wr_csr && host_wdata[3:2] == ACC_MODE && (host_wdata[1] ^ host_wdata[0]);
  wire done    = busy_q && cnt_q == '0;
  wire mapped  = offs_q < OFFS_W'(MAP_DEPTH);
  wire [IDX_W-1:0] idx = {chan_q, offs_q[MAP_W-1:0]};

  wire [BUS_W-1:0] csr_view = BUS_W'({busy_q, 4'b0000, mode_q, 2'b00});

  assign busy = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chan_q  <= '0;
      offs_q  <= '0;
      data_q  <= '0;
      mode_q  <= '0;
      busy_q  <= 1'b0;
      op_rd_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      if (wr_chan) chan_q <= host_wdata[CH_W-1:0];
      if (wr_offs) offs_q <= host_wdata[OFFS_W-1:0];
      if (wr_data)
        data_q <= host_wdata[DATA_W-1:0];
      else if (done && op_rd_q)
        data_q <= mapped ? mem[idx] : '0;
      if (wr_csr) mode_q <= host_wdata[3:2];
      if (cmd_go) begin
        busy_q  <= 1'b1;
        op_rd_q <= host_wdata[1];
        cnt_q   <= CNT_W'(LATENCY - 1);
      end else if (busy_q) begin
        if (cnt_q == '0) busy_q <= 1'b0;
        else             cnt_q  <= cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
    end else if (done && !op_rd_q && mapped) begin
      mem[idx] <= data_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
    end else begin
      host_rvalid <= host_rd;
      if (host_rd) begin
        case (host_addr)
          A_CHAN:  host_rdata <= BUS_W'(chan_q);
          A_OFFS:  host_rdata <= BUS_W'(offs_q);
          A_DATA:  host_rdata <= BUS_W'(data_q);
          A_CSR:   host_rdata <= csr_view;
          default: host_rdata <= '0;
        endcase
      end
    end
  end

  AST_BUSY_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(cmd_go)); // R4

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0) |=> busy_q); // R7

  AST_DUAL_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_csr && host_wdata[1:0] == 2'b11) |=> !busy_q); // R5

  AST_MODE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_csr && host_wdata[3:2] != ACC_MODE) |=> !busy_q); // R6

  AST_WINDOW_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(chan_q) && $stable(offs_q) && $stable(mode_q)); // R8

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_rd_q && !mapped) |=> data_q == '0); // R10

  AST_READ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd |=> host_rvalid); // R11

endmodule

// File: tb/test_chan_cfg_port.sv
`timescale 1ns/1ps
module test_chan_cfg_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  host_addr = '0;
  logic        host_wr = 1'b0;
  logic [31:0] host_wdata = '0;
  logic        host_rd = 1'b0;
  logic [31:0] host_rdata;
  logic        host_rvalid;
  logic        busy;

  chan_cfg_port i_chan_cfg_port (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .busy(busy)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic [15:0] mdl [4][32];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && host_rvalid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R11 unexpected read data", host_rdata, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(host_rdata === e, t, host_rdata, e);
      end
    end
  end

  task automatic bus_write(input logic [6:0] a, input logic [31:0] d);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [6:0] a, input logic [31:0] e, input string t);
    host_addr = a; host_rd = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 100) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic do_write(input int ch, input int off, input logic [15:0] v);
    bus_write(7'h38, ch);
    bus_write(7'h3B, off);
    bus_write(7'h3C, {16'h0, v});
    bus_write(7'h3A, 32'h5);
    wait_idle();
    if (off < 32) mdl[ch][off] = v;
  endtask

  task automatic do_read(input int ch, input int off, input string t);
    bus_write(7'h38, ch);
    bus_write(7'h3B, off);
    bus_write(7'h3A, 32'h6);
    wait_idle();
    bus_read(7'h3C, (off < 32) ? {16'h0, mdl[ch][off]} : 32'h0, t);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog expired", 32'h0, 32'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    foreach (mdl[c, o]) mdl[c][o] = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    check(busy === 1'b0, "R1 busy after reset", busy, 0);
    bus_read(7'h38, 0, "R1 chan reset");
    bus_read(7'h3A, 0, "R1 csr reset");
    bus_read(7'h3B, 0, "R1 offs reset");
    bus_read(7'h3C, 0, "R1 data reset");
    do_read(3, 31, "R1 store reset");

    bus_write(7'h38, 32'hFFFF_FFFF);
    bus_read(7'h38, 32'h3, "R2 chan width");
    bus_write(7'h3B, 32'hFFFF_FFFF);
    bus_read(7'h3B, 32'h1FF, "R2 offs width");
    bus_write(7'h3C, 32'hABCD_1234);
    bus_read(7'h3C, 32'h1234, "R2 data width");
    bus_write(7'h10, 32'h5A5A);
    bus_read(7'h10, 0, "R2 unmapped direct addr");

    bus_write(7'h3A, 32'h4);
    check(busy === 1'b0, "R3 mode-only write no busy", busy, 0);
    bus_read(7'h3A, 32'h4, "R3 mode 1 readback");
    bus_write(7'h3A, 32'hC);
    bus_read(7'h3A, 32'hC, "R3 mode 3 readback");

    bus_write(7'h38, 0);
    bus_write(7'h3B, 5);
    bus_write(7'h3C, 32'hBEEF);
    bus_write(7'h3A, 32'h5);
    for (int i = 0; i < 4; i++) begin
      check(busy === 1'b1, "R7 busy held", busy, 1);
      @(negedge clk);
    end
    check(busy === 1'b0, "R7 busy cleared after 4", busy, 0);
    mdl[0][5] = 16'hBEEF;
    bus_write(7'h3C, 0);
    do_read(0, 5, "R9 R4 read back written word");

    bus_write(7'h38, 1);
    bus_write(7'h3B, 7);
    bus_write(7'h3A, 32'h6);
    bus_read(7'h3A, 32'h104, "R8 status read while busy");
    bus_write(7'h38, 2);
    bus_write(7'h3C, 32'h5555);
    bus_write(7'h3A, 32'h8);
    wait_idle();
    bus_read(7'h38, 1, "R8 chan write ignored while busy");
    bus_read(7'h3A, 32'h4, "R8 csr write ignored while busy");
    bus_read(7'h3C, 0, "R8 R9 data write ignored, read result kept");

    bus_write(7'h3B, 5);
    bus_write(7'h3C, 32'h1111);
    bus_write(7'h3A, 32'h7);
    check(busy === 1'b0, "R5 dual strobe no busy", busy, 0);
    @(negedge clk);
    check(busy === 1'b0, "R5 dual strobe still idle", busy, 0);
    bus_read(7'h3C, 32'h1111, "R5 data untouched");
    bus_read(7'h3A, 32'h4, "R5 mode stored");

    bus_write(7'h3A, 32'h2);
    check(busy === 1'b0, "R6 mode 0 read ignored", busy, 0);
    bus_write(7'h3A, 32'h9);
    check(busy === 1'b0, "R6 mode 2 write ignored", busy, 0);
    bus_read(7'h3C, 32'h1111, "R6 data untouched");
    do_read(0, 5, "R6 store untouched");

    for (int c = 0; c < 4; c++) do_write(c, 31, 16'h1000 + c);
    for (int c = 0; c < 4; c++) do_write(c, 0, 16'h2200 + c);
    for (int c = 0; c < 4; c++) do_read(c, 31, "R10 channel offset 31");
    for (int c = 0; c < 4; c++) do_read(c, 0, "R10 channel offset 0");
    do_write(2, 32, 16'h7777);
    do_write(2, 511, 16'h8888);
    do_read(2, 32, "R10 unmapped read zero");
    do_read(2, 511, "R10 top offset read zero");
    do_read(2, 0, "R10 unmapped write discarded");
    do_read(2, 31, "R10 unmapped write no alias");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R11 all reads returned", exp_q.size(), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule